// File: doc/BRIEF.md
# Gain-Indexed Complex-to-Power Converter

This block turns one complex spectral sample from a single antenna into a power figure and a pair of reduced-width components. The 12-bit sample holds a 6-bit signed real part in its upper half and a 6-bit signed imaginary part in its lower half. A 4-bit gain code travels with each sample. Together, the gain code and the sample form a 16-bit lookup index: the gain code picks one of sixteen 4K-entry tables. The table values are computed by a scaling function, not stored. The components are shifted right by a quarter of the gain code and clipped to 5-bit signed. The power is the squared magnitude, shifted right by half the gain code and clipped to 6-bit unsigned.

The sample and the gain code first land in an input register. One further register stage produces the outputs. Two diagnostic controls act on the conversion stage. The substitute enable freezes the input sample register and feeds a programmable 12-bit word to the converter in place of the live sample. The bank select swaps the scaled tables for a transparent bank that copies raw sample bits to the outputs. The results appear both as separate fields and as two bytes in a fixed layout. A downstream summing network reads that byte layout.

Top module: `cplx_pwr_conv`

## Requirements
- R1: An active-low reset clears the input sample register, the gain register, the diagnostic word and every output to zero.
- R2: A sample and gain code presented at clock edge N are reflected on the outputs after edge N+1, and not before. The substitute enable and the bank select present at edge N act on the outputs after edge N.
- R3: The converter reads sample bits [11:6] as the real part and bits [5:0] as the imaginary part, both two's complement.
- R4: In the scaled bank, each component is arithmetically shifted right by floor(g/4), then saturated to the range -16..15 and output as 5-bit two's complement.
- R5: In the scaled bank, power is (re*re + im*im) shifted right by floor(g/2), then saturated to 63.
- R6: Output byte 0 is {power[5:0], re[1:0]}. Output byte 1 is {re[4:2], im[4:0]}.
- R7: While the substitute enable is high, the converter uses the diagnostic word, and the input sample register keeps its value instead of loading the live sample.
- R8: A write strobe loads the diagnostic word from the write data at that clock edge.
- R9: With bank select high, power = sample[11:6], re = sample[10:6] and im = sample[4:0], whatever the gain code.
- R10: The gain code is registered together with its sample, so each sample is converted with the gain code presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 12 | Live complex sample, real in the upper 6 bits |
| gain_in | input | 4 | Gain code, selects the conversion table |
| diag_en | input | 1 | Substitute the diagnostic word for the live sample |
| bank_sel | input | 1 | 0 = scaled tables, 1 = transparent bank |
| diag_wr | input | 1 | Write strobe for the diagnostic word |
| diag_wdata | input | 12 | Diagnostic word write data |
| byte0_o | output | 8 | Packed power and real low bits |
| byte1_o | output | 8 | Packed real high bits and imaginary |
| pwr_o | output | 6 | Power |
| re_o | output | 5 | Real component |
| im_o | output | 5 | Imaginary component |

## Verification
Sample and gain code changes are due on the outputs two rising edges after they are driven. Changes on the substitute enable, the bank select and a freshly written diagnostic word are due one edge later than that change. The bench keeps a behavioural model with the same two-deep timing built from plain variables. It drives inputs on falling edges and compares every output field and both bytes on every falling edge, so an early or late result fails in the cycle it appears. Gain sweeps cover every shift amount at both saturation limits.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int CPC_SMP_W  = 12;
    localparam int CPC_GAIN_W = 4;
    localparam int CPC_PWR_W  = 6;
    localparam int CPC_CMP_W  = 5;
    localparam int CPC_BYTE_W = 8;

    typedef enum logic {
        BANK_SCALED = 1'b0,
        BANK_RAW    = 1'b1
    } cpc_bank_e;
endpackage

// File: rtl/cpc_in_stage.sv
module cpc_in_stage #(
    parameter int SMP_W  = 12,
    parameter int GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              diag_en,
    input  logic              diag_wr,
    input  logic [SMP_W-1:0]  diag_wdata,
    output logic [SMP_W-1:0]  conv_smp,
    output logic [GAIN_W-1:0] conv_gain
);
    logic [SMP_W-1:0]  smp_q;
    logic [SMP_W-1:0]  diag_q;
    logic [GAIN_W-1:0] gain_q;

    // live sample register: frozen while the substitute path is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= '0;
            gain_q <= '0;
        end else begin
            if (!diag_en) smp_q <= smp_in;
            gain_q <= gain_in;
        end
    end

    // programmable substitute word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       diag_q <= '0;
        else if (diag_wr) diag_q <= diag_wdata;
    end

    always_comb begin
        conv_smp  = diag_en ? diag_q : smp_q;
        conv_gain = gain_q;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        diag_en |=> $stable(smp_q));

    assert_live_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_en |=> smp_q == $past(smp_in));

    assert_diag_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        diag_wr |=> diag_q == $past(diag_wdata));

    assert_gain_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> conv_gain == $past(gain_in));
endmodule

// File: rtl/cpc_comp_scale.sv
module cpc_comp_scale #(
    parameter int IN_W  = 6,
    parameter int OUT_W = 5,
    parameter int SH_W  = 4
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] MAXV = IN_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] MINV = IN_W'(-(2 ** (OUT_W - 1)));

    logic signed [IN_W-1:0] shifted;

    always_comb begin
        shifted = din >>> sh;
        if (shifted > MAXV)      dout = MAXV[OUT_W-1:0];
        else if (shifted < MINV) dout = MINV[OUT_W-1:0];
        else                     dout = shifted[OUT_W-1:0];
    end

    // the sign survives shifting and clipping
    always_comb begin
        assert_sign_keep_R4: assert ((din < 0) == (dout < 0));
    end
endmodule

// File: rtl/cpc_pwr_scale.sv
module cpc_pwr_scale #(
    parameter int CIN_W = 6,
    parameter int OUT_W = 6,
    parameter int SH_W  = 4
) (
    input  logic signed [CIN_W-1:0] re,
    input  logic signed [CIN_W-1:0] im,
    input  logic        [SH_W-1:0]  sh,
    output logic        [OUT_W-1:0] dout
);
    localparam int SQ_W = 2 * CIN_W;
    localparam logic [SQ_W-1:0] MAXP = SQ_W'((2 ** OUT_W) - 1);

    logic signed [SQ_W-1:0] re_x, im_x, re_sq, im_sq;
    logic        [SQ_W-1:0] mag, shifted;

    always_comb begin
        re_x    = SQ_W'(re);
        im_x    = SQ_W'(im);
        re_sq   = re_x * re_x;
        im_sq   = im_x * im_x;
        mag     = SQ_W'(re_sq) + SQ_W'(im_sq);
        shifted = mag >> sh;
        dout    = (shifted > MAXP) ? MAXP[OUT_W-1:0] : shifted[OUT_W-1:0];
    end

    always_comb begin
        if (re == '0 && im == '0) assert_zero_in_R5: assert (dout == '0);
    end
endmodule

// File: rtl/cplx_pwr_conv.sv
module cplx_pwr_conv
    import cpc_pkg::*;
#(
    parameter int SMP_W  = CPC_SMP_W,
    parameter int GAIN_W = CPC_GAIN_W,
    parameter int PWR_W  = CPC_PWR_W,
    parameter int CMP_W  = CPC_CMP_W,
    parameter int BYTE_W = CPC_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic [GAIN_W-1:0] gain_in,
    input  logic              diag_en,
    input  logic              bank_sel,
    input  logic              diag_wr,
    input  logic [SMP_W-1:0]  diag_wdata,
    output logic [BYTE_W-1:0] byte0_o,
    output logic [BYTE_W-1:0] byte1_o,
    output logic [PWR_W-1:0]  pwr_o,
    output logic [CMP_W-1:0]  re_o,
    output logic [CMP_W-1:0]  im_o
);
    localparam int HALF_W = SMP_W / 2;
    localparam int RE_LO  = BYTE_W - PWR_W;
    localparam int NCOMP  = 2;

    logic [SMP_W-1:0]  conv_smp;
    logic [GAIN_W-1:0] conv_gain;
    logic [GAIN_W-1:0] cmp_sh, pwr_sh;

    logic signed [HALF_W-1:0] comp_raw [NCOMP];
    logic signed [CMP_W-1:0]  comp_scl [NCOMP];
    logic        [PWR_W-1:0]  pwr_scl;

    logic [PWR_W-1:0] nxt_pwr, pwr_q;
    logic [CMP_W-1:0] nxt_re, nxt_im, re_q, im_q;
    cpc_bank_e        bank;

    cpc_in_stage #(.SMP_W(SMP_W), .GAIN_W(GAIN_W)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_in     (smp_in),
        .gain_in    (gain_in),
        .diag_en    (diag_en),
        .diag_wr    (diag_wr),
        .diag_wdata (diag_wdata),
        .conv_smp   (conv_smp),
        .conv_gain  (conv_gain)
    );

    always_comb begin
        cmp_sh      = conv_gain >> 2;
        pwr_sh      = conv_gain >> 1;
        comp_raw[0] = conv_smp[SMP_W-1 -: HALF_W];
        comp_raw[1] = conv_smp[HALF_W-1:0];
        bank        = cpc_bank_e'(bank_sel);
    end

    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
        cpc_comp_scale #(.IN_W(HALF_W), .OUT_W(CMP_W), .SH_W(GAIN_W)) u_cs (
            .din  (comp_raw[k]),
            .sh   (cmp_sh),
            .dout (comp_scl[k])
        );
    end

    cpc_pwr_scale #(.CIN_W(HALF_W), .OUT_W(PWR_W), .SH_W(GAIN_W)) u_ps (
        .re   (comp_raw[0]),
        .im   (comp_raw[1]),
        .sh   (pwr_sh),
        .dout (pwr_scl)
    );

    always_comb begin
        unique case (bank)
            BANK_SCALED: begin
                nxt_pwr = pwr_scl;
                nxt_re  = comp_scl[0];
                nxt_im  = comp_scl[1];
            end
            BANK_RAW: begin
                nxt_pwr = conv_smp[SMP_W-1 -: PWR_W];
                nxt_re  = conv_smp[SMP_W-2 -: CMP_W];
                nxt_im  = conv_smp[CMP_W-1:0];
            end
            default: begin
                nxt_pwr = '0;
                nxt_re  = '0;
                nxt_im  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= '0;
            re_q  <= '0;
            im_q  <= '0;
        end else begin
            pwr_q <= nxt_pwr;
            re_q  <= nxt_re;
            im_q  <= nxt_im;
        end
    end

    always_comb begin
        pwr_o   = pwr_q;
        re_o    = re_q;
        im_o    = im_q;
        byte0_o = {pwr_q, re_q[RE_LO-1:0]};
        byte1_o = {re_q[CMP_W-1:RE_LO], im_q};
    end

    assert_raw_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |=> pwr_o == $past(conv_smp[SMP_W-1 -: PWR_W]));

    assert_scaled_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel && conv_smp == '0) |=> (pwr_o == '0 && re_o == '0 && im_o == '0));
endmodule

// File: tb/sim_cplx_pwr_conv.sv
module sim_cplx_pwr_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_in = '0;
    logic [3:0]  gain_in = '0;
    logic        diag_en = 1'b0;
    logic        bank_sel = 1'b0;
    logic        diag_wr = 1'b0;
    logic [11:0] diag_wdata = '0;
    logic [7:0]  byte0_o, byte1_o;
    logic [5:0]  pwr_o;
    logic [4:0]  re_o, im_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference state
    logic [11:0] m_smp = '0, m_diag = '0;
    logic [3:0]  m_gain = '0;
    logic [15:0] m_out = '0;

    always #10 clk = ~clk;

    cplx_pwr_conv u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .gain_in(gain_in),
        .diag_en(diag_en), .bank_sel(bank_sel), .diag_wr(diag_wr),
        .diag_wdata(diag_wdata), .byte0_o(byte0_o), .byte1_o(byte1_o),
        .pwr_o(pwr_o), .re_o(re_o), .im_o(im_o)
    );

    function automatic logic [15:0] ref_conv(input logic [11:0] s, input logic [3:0] g,
                                             input logic b);
        integer r, i, p;
        if (b) return {s[11:6], s[10:6], s[4:0]};
        r = s[11:6]; if (r > 31) r -= 64;
        i = s[5:0];  if (i > 31) i -= 64;
        p = (r * r + i * i) >> (g / 2);
        if (p > 63) p = 63;
        r = r >>> (g / 4);
        i = i >>> (g / 4);
        if (r > 15) r = 15; if (r < -16) r = -16;
        if (i > 15) i = 15; if (i < -16) i = -16;
        return {6'(p), 5'(r), 5'(i)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_smp <= '0; m_diag <= '0; m_gain <= '0; m_out <= '0;
        end else begin
            m_out  <= ref_conv(diag_en ? m_diag : m_smp, m_gain, bank_sel);
            if (!diag_en) m_smp <= smp_in;
            m_gain <= gain_in;
            if (diag_wr) m_diag <= diag_wdata;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        check(tag, {pwr_o, re_o, im_o}, m_out);
        check("R6", {byte0_o, byte1_o},
              {m_out[15:10], m_out[6:5], m_out[9:7], m_out[4:0]});
    end

    task automatic step(input logic [11:0] s, input logic [3:0] g);
        smp_in = s; gain_in = g;
        @(negedge clk);
    endtask

    initial begin
        #100000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", {byte0_o, byte1_o, pwr_o, re_o, im_o}, 32'h0);
        rst_n = 1'b1;
        diag_en = 1'b1;              // cleared diagnostic word must convert to zero
        step(12'hFFF, 4'd0);
        step(12'hFFF, 4'd0);
        check("R1", {pwr_o, re_o, im_o}, 16'h0);
        diag_en = 1'b0;

        tag = "R2";
        step(12'h041, 4'd0);
        check("R2", {pwr_o, re_o, im_o}, 16'h0);   // not yet visible
        step(12'h000, 4'd0);
        check("R2", {pwr_o, re_o, im_o}, ref_conv(12'h041, 4'd0, 1'b0));
        step(12'h0C3, 4'd1); step(12'h105, 4'd2); step(12'h000, 4'd0);

        tag = "R3";
        step(12'h800, 4'd0); step(12'h03F, 4'd0); step(12'h7DF, 4'd0);
        step(12'hFC1, 4'd0); step(12'h820, 4'd0); step(12'h000, 4'd0);

        tag = "R4";
        for (int g = 0; g < 16; g++) begin
            step(12'h7E0, 4'(g)); step(12'h81F, 4'(g)); step(12'hA5A, 4'(g));
        end
        tag = "R5";
        for (int g = 0; g < 16; g++) begin
            step(12'h820, 4'(g)); step(12'h3C4, 4'(g)); step(12'h0C3, 4'(g));
        end

        tag = "R10";
        for (int n = 0; n < 24; n++) step(12'($urandom), 4'($urandom));

        tag = "R8";
        diag_wr = 1'b1; diag_wdata = 12'h7E1; step(12'h000, 4'd0);
        diag_wr = 1'b0; diag_en = 1'b1;
        step(12'h000, 4'd0); step(12'h000, 4'd5);
        diag_wr = 1'b1; diag_wdata = 12'h8C3; step(12'h000, 4'd0);
        diag_wr = 1'b0; step(12'h000, 4'd0); step(12'h000, 4'd0);

        tag = "R7";
        diag_en = 1'b0; step(12'h3A7, 4'd0);       // load a live sample
        diag_en = 1'b1;
        for (int n = 0; n < 6; n++) step(12'($urandom), 4'(n));
        diag_en = 1'b0;                            // held sample appears once
        step(12'h111, 4'd0); step(12'h000, 4'd0); step(12'h000, 4'd0);

        tag = "R9";
        bank_sel = 1'b1;
        for (int n = 0; n < 16; n++) step(12'($urandom), 4'(n));
        bank_sel = 1'b0; step(12'h000, 4'd0); step(12'h000, 4'd0);

        tag = "R1";
        step(12'h7FF, 4'd0); step(12'h7FF, 4'd0);
        rst_n = 1'b0; @(negedge clk);
        check("R1", {byte0_o, byte1_o}, 16'h0);
        rst_n = 1'b1; step(12'h000, 4'd0); step(12'h000, 4'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule